// File: doc/BRIEF.md
# Multiword DMA Host Burst Engine

This block is the host end of a 16-bit multiword DMA link to a storage device. When it is armed and the device raises its request line, the engine pulls the active-low acknowledge low. It then produces a run of read or write strobes, and each strobe moves one word. On writes, words are pulled from a valid/ready source and driven onto the data bus. On reads, the bus is sampled in the last cycle of each strobe, and the word is handed to a sink as a one-cycle pulse.

Strobe timing is picked at burst start from one of three timing grades. The grades are given in nanoseconds and converted to clock counts for the configured clock period, rounded up. Each word has a fixed strobe-low time. The strobe-high time that follows is the larger of two values: the direction's minimum negation time, or the remainder needed to reach the grade's minimum word period.

A burst ends only at a word boundary. It ends when the resynchronized request is low at the moment a strobe is released, when the host raises its stop input, or, on writes, when the source has no further word. While acknowledge is low, the pass-through chip selects are forced inactive and the width flag reports a 16-bit transfer.

Top module: `mdma_host_engine`

## Requirements
- R1: After reset, dmack_no, dior_no and diow_no are high, and src_ready_o, snk_valid_o and dd_oe_o are low.
- R2: A burst starts only when en_i is high and the request, after a two-flop resynchronizer, is high. Acknowledge goes low one cycle before the first strobe. No strobe is ever asserted while acknowledge is high.
- R3: While dmack_no is low, cs_n_o is 2'b11 and wide_o is 1. While dmack_no is high, cs_n_o follows cs_n_i.
- R4: With a 10 ns clock, each strobe is low for exactly 22, 8 or 7 cycles for mode_i 0, 1 or 2. These are the ceilings of 215, 80 and 70 ns.
- R5: Between consecutive strobes of a burst, the strobe is high for max(ceil(neg_ns/T), ceil(cycle_ns/T) − low cycles). Word periods are 480/150/120 ns. Read negation is 50/50/25 ns and write negation is 215/50/25 ns. At 10 ns this gives 26, 7 and 5 cycles in both directions.
- R6: With wr_i = 1, each strobe consumes exactly one source word, taken with src_ready_o at strobe start. dd_o holds that word, with dd_oe_o high, for the whole strobe-low time.
- R7: With wr_i = 0, dd_i is sampled in the last strobe-low cycle. It appears on snk_data_o with a one-cycle snk_valid_o pulse in the next cycle, and exactly one pulse occurs per strobe.
- R8: If the resynchronized request is low when a strobe is released, no further strobe follows. Acknowledge then rises after the R5 negation count, which is at least the 20/5/5 ns release hold.
- R9: A high stop_i, or (on writes) a low src_valid_i, seen at strobe release ends the burst in the same way as R8. Raising stop_i during a strobe does not shorten that strobe.
- R10: mode_i = 3 uses the mode 0 timing.
- R11: A write burst does not start while src_valid_i is low. Acknowledge stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Arms the engine to answer requests |
| wr_i | input | 1 | Burst direction, 1 = host to device |
| mode_i | input | 2 | Timing grade, latched at burst start |
| stop_i | input | 1 | Host request to end the burst at the next word boundary |
| dmarq_i | input | 1 | Device DMA request (asynchronous) |
| dmack_no | output | 1 | DMA acknowledge, active low |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| cs_n_i | input | 2 | Chip selects from the register-access path |
| cs_n_o | output | 2 | Chip selects to the device |
| wide_o | output | 1 | 16-bit transfer in progress |
| dd_i | input | 16 | Data bus from device |
| dd_o | output | 16 | Data bus to device |
| dd_oe_o | output | 1 | Data bus drive enable |
| src_valid_i | input | 1 | Write source holds a word |
| src_data_i | input | 16 | Write source word |
| src_ready_o | output | 1 | Write source word taken |
| snk_valid_o | output | 1 | Read word valid pulse |
| snk_data_o | output | 16 | Read word |

## Verification
The word-boundary decision at strobe release and a termination cause can land in the same cycle. The termination cause is a dropped request, a stop, or an exhausted source. On reads, the final sink capture also falls in that cycle. The bench sweeps every mode in both directions with one-word and three-word bursts, and raises each termination cause during the final strobe. It then judges the result from the strobe count, every strobe-low and strobe-high width, the acknowledge tail, and the data moved. An idle stretch follows each burst to show that no stray strobe appears.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK,
    ST_STB,
    ST_NEG
  } mdma_state_e;

  function automatic int unsigned cdiv(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction

  // grade 3 falls back to the slowest grade
  function automatic int unsigned t_cycle_ns(input logic [1:0] m);
    case (m)
      2'd1:    return 150;
      2'd2:    return 120;
      default: return 480;
    endcase
  endfunction

  function automatic int unsigned t_assert_ns(input logic [1:0] m);
    case (m)
      2'd1:    return 80;
      2'd2:    return 70;
      default: return 215;
    endcase
  endfunction

  function automatic int unsigned t_neg_rd_ns(input logic [1:0] m);
    case (m)
      2'd1:    return 50;
      2'd2:    return 25;
      default: return 50;
    endcase
  endfunction

  function automatic int unsigned t_neg_wr_ns(input logic [1:0] m);
    case (m)
      2'd1:    return 50;
      2'd2:    return 25;
      default: return 215;
    endcase
  endfunction

  function automatic int unsigned t_ack_hold_ns(input logic [1:0] m);
    case (m)
      2'd1:    return 5;
      2'd2:    return 5;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/mdma_req_sync.sv
module mdma_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff_q[g] <= 1'b0;
      end else if (g == 0) begin
        ff_q[g] <= d_i;
      end else begin
        ff_q[g] <= ff_q[(g > 0) ? g - 1 : 0];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/mdma_timing.sv
module mdma_timing
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned CW     = 6
) (
  input  logic [1:0]    mode_i,
  input  logic          wr_i,
  output logic [CW-1:0] asrt_o,
  output logic [CW-1:0] neg_o
);

  logic [CW-1:0] asrt_tab  [4];
  logic [CW-1:0] neg_r_tab [4];
  logic [CW-1:0] neg_w_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_mode
    localparam int unsigned ACNT = cdiv(t_assert_ns(2'(g)), CLK_NS);
    localparam int unsigned CCNT = cdiv(t_cycle_ns(2'(g)), CLK_NS);
    localparam int unsigned FILL = (CCNT > ACNT) ? CCNT - ACNT : 1;
    localparam int unsigned RCNT = cdiv(t_neg_rd_ns(2'(g)), CLK_NS);
    localparam int unsigned WCNT = cdiv(t_neg_wr_ns(2'(g)), CLK_NS);
    localparam int unsigned RNEG = (RCNT > FILL) ? RCNT : FILL;
    localparam int unsigned WNEG = (WCNT > FILL) ? WCNT : FILL;
    assign asrt_tab[g]  = CW'(ACNT);
    assign neg_r_tab[g] = CW'(RNEG);
    assign neg_w_tab[g] = CW'(WNEG);
  end

  assign asrt_o = asrt_tab[mode_i];
  assign neg_o  = wr_i ? neg_w_tab[mode_i] : neg_r_tab[mode_i];

endmodule

// File: rtl/mdma_host_engine.sv
module mdma_host_engine
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [1:0]    mode_i,
  input  logic          stop_i,
  input  logic          dmarq_i,
  output logic          dmack_no,
  output logic          dior_no,
  output logic          diow_no,
  input  logic [1:0]    cs_n_i,
  output logic [1:0]    cs_n_o,
  output logic          wide_o,
  input  logic [DW-1:0] dd_i,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o,
  input  logic          src_valid_i,
  input  logic [DW-1:0] src_data_i,
  output logic          src_ready_o,
  output logic          snk_valid_o,
  output logic [DW-1:0] snk_data_o
);

  localparam int unsigned MAXC = cdiv(t_cycle_ns(2'd0), CLK_NS);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  mdma_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_q, last_d;
  logic [1:0]    mode_q;
  logic          wr_q;
  logic [DW-1:0] wdat_q;
  logic          pop;
  logic          cap;
  logic          rq_s;
  logic          start;
  logic          cont;
  logic [CW-1:0] asrt_cnt, neg_cnt;

  mdma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dmarq_i),
    .q_o   (rq_s)
  );

  mdma_timing #(.CLK_NS(CLK_NS), .CW(CW)) u_tim (
    .mode_i(mode_q),
    .wr_i  (wr_q),
    .asrt_o(asrt_cnt),
    .neg_o (neg_cnt)
  );

  assign start = en_i && rq_s && !stop_i && (!wr_i || src_valid_i);
  // word-boundary continuation test, taken at strobe release
  assign cont  = en_i && rq_s && !stop_i && (!wr_q || src_valid_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    pop     = 1'b0;
    cap     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_d = ST_ACK;
      end
      ST_ACK: begin
        state_d = ST_STB;
        cnt_d   = asrt_cnt - 1'b1;
        pop     = wr_q;
      end
      ST_STB: begin
        if (cnt_q == '0) begin
          state_d = ST_NEG;
          cnt_d   = neg_cnt - 1'b1;
          last_d  = !cont;
          cap     = !wr_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_NEG: begin
        if (cnt_q == '0) begin
          if (last_q) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_STB;
            cnt_d   = asrt_cnt - 1'b1;
            pop     = wr_q;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      mode_q  <= 2'd0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      if (state_q == ST_IDLE && start) begin
        mode_q <= mode_i;
        wr_q   <= wr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdat_q      <= '0;
      snk_valid_o <= 1'b0;
      snk_data_o  <= '0;
    end else begin
      if (pop) wdat_q <= src_data_i;
      snk_valid_o <= cap;
      if (cap) snk_data_o <= dd_i;
    end
  end

  assign src_ready_o = pop;
  assign dmack_no    = (state_q == ST_IDLE);
  assign dior_no     = !(state_q == ST_STB && !wr_q);
  assign diow_no     = !(state_q == ST_STB && wr_q);
  assign cs_n_o      = dmack_no ? cs_n_i : 2'b11;
  assign wide_o      = !dmack_no;
  assign dd_o        = wdat_q;
  assign dd_oe_o     = wr_q && (state_q == ST_STB || state_q == ST_NEG);

endmodule

// File: rtl/mdma_host_engine_chk.sv
module mdma_host_engine_chk
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned DW     = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dmack_no,
  input logic          dior_no,
  input logic          diow_no,
  input logic [1:0]    cs_n_o,
  input logic          wide_o,
  input logic [DW-1:0] dd_o,
  input logic          dd_oe_o,
  input logic [1:0]    mode_q
);

  logic       strb, strb_q, seen_fall;
  logic [7:0] low_cnt, per_cnt, since_rel;
  int unsigned amin, cmin, hmin;

  assign strb = !dior_no || !diow_no;
  assign amin = cdiv(t_assert_ns(mode_q), CLK_NS);
  assign cmin = cdiv(t_cycle_ns(mode_q), CLK_NS);
  assign hmin = cdiv(t_ack_hold_ns(mode_q), CLK_NS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q    <= 1'b0;
      seen_fall <= 1'b0;
      low_cnt   <= '0;
      per_cnt   <= '0;
      since_rel <= '0;
    end else begin
      strb_q <= strb;
      if (strb) low_cnt <= strb_q ? low_cnt + 8'd1 : 8'd1;
      if (strb && !strb_q) per_cnt <= 8'd1;
      else if (per_cnt != 8'hff) per_cnt <= per_cnt + 8'd1;
      if (strb) since_rel <= '0;
      else if (since_rel != 8'hff) since_rel <= since_rel + 8'd1;
      if (dmack_no) seen_fall <= 1'b0;
      else if (strb && !strb_q) seen_fall <= 1'b1;
    end
  end

  a_r3_cs_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dmack_no |-> (cs_n_o == 2'b11) && wide_o);

  a_r2_strobe_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb |-> !dmack_no);

  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no));

  a_r4_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_q && !strb) |-> (32'(low_cnt) >= amin));

  a_r5_word_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb && !strb_q && seen_fall) |-> (32'(per_cnt) >= cmin));

  a_r8_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dmack_no) |-> (32'(since_rel) >= hmin));

  a_r6_wdata_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!diow_no && $past(!diow_no)) |-> $stable(dd_o));

  a_r6_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !diow_no |-> dd_oe_o);

endmodule

bind mdma_host_engine mdma_host_engine_chk #(.CLK_NS(CLK_NS), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dmack_no(dmack_no),
  .dior_no (dior_no),
  .diow_no (diow_no),
  .cs_n_o  (cs_n_o),
  .wide_o  (wide_o),
  .dd_o    (dd_o),
  .dd_oe_o (dd_oe_o),
  .mode_q  (mode_q)
);

// File: tb/sim_mdma_host_engine.sv
module sim_mdma_host_engine;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, wr_i = 1'b0, stop_i = 1'b0, dmarq_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [1:0]  cs_n_i = 2'b00;
  logic        dmack_no, dior_no, diow_no, wide_o, dd_oe_o;
  logic [1:0]  cs_n_o;
  logic [15:0] dd_i, dd_o, src_data_i, snk_data_o;
  logic        src_valid_i, src_ready_o, snk_valid_o;

  int total = 0, failed = 0, cyc = 0;
  int idx = 0, n_avail = 0, bid = 0;
  int words = 0, rcnt = 0, low_run = 0, hi_run = 0, tail = -1, cs_bad = 0, oe_bad = 0;
  int width [8];
  int gap   [8];
  int wdat  [8];
  int rdat  [8];
  logic prev = 1'b0, prev_ack = 1'b0, strb_now = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdma_host_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .wr_i(wr_i), .mode_i(mode_i),
    .stop_i(stop_i), .dmarq_i(dmarq_i), .dmack_no(dmack_no), .dior_no(dior_no),
    .diow_no(diow_no), .cs_n_i(cs_n_i), .cs_n_o(cs_n_o), .wide_o(wide_o),
    .dd_i(dd_i), .dd_o(dd_o), .dd_oe_o(dd_oe_o), .src_valid_i(src_valid_i),
    .src_data_i(src_data_i), .src_ready_o(src_ready_o), .snk_valid_o(snk_valid_o),
    .snk_data_o(snk_data_o)
  );

  assign src_valid_i = (idx < n_avail);
  assign src_data_i  = 16'(32'h5000 + bid * 32 + idx);
  assign dd_i        = 16'(32'hA000 + 256 * int'(mode_i) + words);

  always @(posedge clk) if (src_ready_o && src_valid_i) idx <= idx + 1;

  // strobe/ack monitor, away from the active edge
  always @(negedge clk) begin
    strb_now = !dior_no || !diow_no;
    if (!dmack_no && (cs_n_o != 2'b11 || !wide_o)) cs_bad++;
    if (strb_now) begin
      if (!prev) begin
        if (words > 0 && words < 9) gap[words-1] = hi_run;
        low_run = 1;
      end else low_run++;
      if (!diow_no && words < 8) begin
        wdat[words] = int'(dd_o);
        if (!dd_oe_o) oe_bad++;
      end
    end else begin
      if (prev) begin
        if (words < 8) width[words] = low_run;
        words++;
        hi_run = 1;
      end else if (!dmack_no) hi_run++;
      if (prev_ack && dmack_no) tail = hi_run;
    end
    if (snk_valid_o) begin
      if (rcnt < 8) rdat[rcnt] = int'(snk_data_o);
      rcnt++;
    end
    prev     = strb_now;
    prev_ack = !dmack_no;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cd(input int n);
    return (n + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction

  function automatic int exp_low(input int m);
    case (m)
      1: return cd(80);
      2: return cd(70);
      default: return cd(215);
    endcase
  endfunction

  function automatic int exp_neg(input int m, input bit wr);
    int cyc_c, n;
    case (m)
      1: begin cyc_c = cd(150); n = cd(50); end
      2: begin cyc_c = cd(120); n = cd(25); end
      default: begin cyc_c = cd(480); n = wr ? cd(215) : cd(50); end
    endcase
    return (n > cyc_c - exp_low(m)) ? n : cyc_c - exp_low(m);
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // kind: 0 = device drops request, 1 = host stop, 2 = source runs dry
  task automatic run_burst(input int m, input bit wr, input int n, input int kind);
    string tag;
    int el, en_exp;
    bid++;
    tick(1);
    words = 0; rcnt = 0; low_run = 0; hi_run = 0; tail = -1; cs_bad = 0; oe_bad = 0;
    idx = 0;
    n_avail = (kind == 2) ? n : 1000;
    mode_i = 2'(m);
    wr_i = wr;
    en_i = 1'b1;
    dmarq_i = 1'b1;
    do tick(1); while (!(words == n - 1 && strb_now));
    if (kind == 0) dmarq_i = 1'b0;
    if (kind == 1) stop_i = 1'b1;
    do tick(1); while (!dmack_no);
    tick(1);
    en_i = 1'b0; dmarq_i = 1'b0; stop_i = 1'b0;
    tag = (kind == 0) ? "R8" : "R9";
    el = exp_low(m);
    en_exp = exp_neg(m, wr);
    chk(words == n, tag, words, n);
    for (int k = 0; k < n && k < 8; k++) begin
      chk(width[k] == el, (m == 3) ? "R10 R4" : "R4", width[k], el);
      if (k < n - 1) chk(gap[k] == en_exp, (m == 3) ? "R10 R5" : "R5", gap[k], en_exp);
      if (wr) chk(wdat[k] == 32'h5000 + bid * 32 + k, "R6", wdat[k], 32'h5000 + bid * 32 + k);
      else chk(rdat[k] == 32'hA000 + 256 * m + k, "R7", rdat[k], 32'hA000 + 256 * m + k);
    end
    chk(tail == en_exp, tag, tail, en_exp);
    chk(cs_bad == 0, "R3", cs_bad, 0);
    if (wr) begin
      chk(idx == n, "R6", idx, n);
      chk(oe_bad == 0, "R6", oe_bad, 0);
    end else chk(rcnt == n, "R7", rcnt, n);
    tick(40);
    chk(words == n, tag, words, n);
    chk(dmack_no == 1'b1, tag, int'(dmack_no), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk(dmack_no && dior_no && diow_no, "R1", int'({dmack_no, dior_no, diow_no}), 7);
    chk(!src_ready_o && !snk_valid_o && !dd_oe_o, "R1",
        int'({src_ready_o, snk_valid_o, dd_oe_o}), 0);
    rst_ni = 1'b1;
    tick(2);
    chk(cs_n_o == cs_n_i, "R3", int'(cs_n_o), int'(cs_n_i));

    // R2: request alone does nothing while disarmed
    dmarq_i = 1'b1;
    tick(20);
    chk(dmack_no == 1'b1, "R2", int'(dmack_no), 1);
    // R11: armed write with empty source stays idle
    wr_i = 1'b1; n_avail = 0; idx = 0; en_i = 1'b1;
    tick(20);
    chk(dmack_no == 1'b1 && words == 0, "R11", int'(dmack_no), 1);
    en_i = 1'b0; dmarq_i = 1'b0;
    tick(5);

    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 3; n += 2) begin
        run_burst(m, 1'b0, n, 0);
        run_burst(m, 1'b0, n, 1);
        run_burst(m, 1'b1, n, 0);
        run_burst(m, 1'b1, n, 1);
        run_burst(m, 1'b1, n, 2);
      end
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule